// File: doc/BRIEF.md
# Packed Media Arithmetic Unit

This block is a pipelined SIMD integer unit for audio and video inner loops. It takes two 64-bit source words and splits each of them into equal lanes of 8, 16 or 32 bits. Every lane applies the same operation to its own pair of elements: an average that rounds upward, an absolute difference, a minimum or a maximum. Lane width, operation and signedness are chosen per transaction, so a stream of mixed operations can be issued back to back with one new word accepted on every clock.

The unit has a fixed two-cycle latency and no backpressure. A valid strobe travels beside the data, so the caller only needs to watch the output valid flag. Lanes never interact: carries and borrows stop at lane boundaries. Saturation, multiplication, floating point and horizontal reductions are handled elsewhere.

Top module: `media_simd_alu`

## Requirements
- R1: With opcode 0 (average) and the signed flag clear, each lane returns bits [W:1] of the (W+1)-bit sum a + b + 1, where a and b are read as unsigned lane values.
- R2: With opcode 0 and the signed flag set, both lane operands are sign-extended by one bit before the sum a + b + 1, so each lane holds floor((a + b + 1) / 2) in two's complement (for example a = -1, b = -2 gives -1).
- R3: With opcode 1 (absolute difference), each lane returns a - b when a > b and b - a otherwise, with a and b compared as unsigned; the signed flag has no effect on this opcode.
- R4: With opcode 2 (minimum), each lane returns a when a < b and b otherwise, compared as signed when the signed flag is set and as unsigned when it is clear.
- R5: With opcode 3 (maximum), each lane returns a when a > b and b otherwise, with the same signedness rule as R4.
- R6: Width select 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes and 2 gives two 32-bit lanes; lane i occupies bits [i*W +: W] of every word. Width select 3 yields an all-zero result.
- R7: No carry or borrow crosses a lane boundary; all-ones and sign-boundary operands give each lane exactly its own isolated result.
- R8: Opcodes 4 to 7 yield an all-zero result.
- R9: A word presented with in_valid high in cycle t appears on out_data with out_valid high in cycle t + 2; a new word may be accepted every cycle and out_valid is high only for accepted words.
- R10: While rst_n is low (synchronous, active low), out_valid and out_data are driven to zero from the next clock edge on.
- R11: In a cycle where out_valid is low, out_data keeps the value of the last valid result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Source words and controls are valid this cycle |
| in_a | input | 64 | First source word (operand a of every lane) |
| in_b | input | 64 | Second source word (operand b of every lane) |
| in_op | input | 3 | Opcode: 0 average, 1 absolute difference, 2 minimum, 3 maximum, 4-7 zero |
| in_width | input | 2 | Lane width select: 0 = 8, 1 = 16, 2 = 32 bits, 3 = zero result |
| in_signed | input | 1 | Treat lanes as two's complement for average, minimum and maximum |
| out_valid | output | 1 | Result word is valid this cycle |
| out_data | output | 64 | Packed lane results |

## Verification
The assertions watch the valid pipeline's two-cycle timing, the all-zero result for unused opcodes and the reserved width, the holding of the result between valid words, and the clearing of the outputs under reset on every cycle. The lane arithmetic itself, including rounding of signed averages, the unsigned comparison inside the absolute difference and the isolation of lanes at all-ones and sign-boundary patterns, can only be shown by the bench's sweeps: every pair of 8-bit values for every operation and signedness, plus boundary and pseudo-random words at 16 and 32 bits.

// File: rtl/media_simd_pkg.sv
// Package: shared constants and encodings for the packed media arithmetic unit.
// Assumes the data word is a multiple of the widest lane.
package media_simd_pkg;

    // Opcode field width and the four defined operations; other codes give zero.
    localparam int OP_W = 3;
    localparam logic [OP_W-1:0] OP_AVG  = 3'd0;
    localparam logic [OP_W-1:0] OP_ABSD = 3'd1;
    localparam logic [OP_W-1:0] OP_MIN  = 3'd2;
    localparam logic [OP_W-1:0] OP_MAX  = 3'd3;

    // Lane width select encodings; code 3 is reserved and gives zero.
    localparam int WSEL_W = 2;
    typedef enum logic [WSEL_W-1:0] {
        WSEL_8   = 2'd0,
        WSEL_16  = 2'd1,
        WSEL_32  = 2'd2,
        WSEL_RSV = 2'd3
    } lane_wsel_e;

    // Smallest lane and the number of supported lane widths (each doubling).
    localparam int MIN_LANE_W = 8;
    localparam int NUM_WIDTHS = 3;

endpackage

// File: rtl/media_lane.sv
// Module: media_lane
// Computes one lane's result for the selected operation. Purely combinational.
// Assumes: op codes from media_simd_pkg; sgn selects two's complement reading
// for average, minimum and maximum; the absolute difference is always unsigned.
module media_lane
    import media_simd_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  logic [OP_W-1:0]   op,
    input  logic              sgn,
    output logic [LANE_W-1:0] res
);

    localparam int SUM_W = LANE_W + 1;

    logic             ext_a;
    logic             ext_b;
    logic [SUM_W-1:0] sum_rnd;
    logic [LANE_W-1:0] avg_res;
    logic             a_gt_b;
    logic             a_lt_b;
    logic             a_gt_b_u;
    logic [LANE_W-1:0] diff_ab;
    logic [LANE_W-1:0] diff_ba;

    // Widened rounding sum: top bit is the sign extension for signed lanes.
    always_comb begin
        ext_a   = sgn & a[LANE_W-1];
        ext_b   = sgn & b[LANE_W-1];
        sum_rnd = {ext_a, a} + {ext_b, b} + SUM_W'(1);
        avg_res = sum_rnd[SUM_W-1:1];
    end

    // Comparisons in the requested signedness, plus the unsigned one for abs-diff.
    always_comb begin
        a_gt_b_u = (a > b);
        if (sgn) begin
            a_gt_b = ($signed(a) > $signed(b));
            a_lt_b = ($signed(a) < $signed(b));
        end else begin
            a_gt_b = a_gt_b_u;
            a_lt_b = (a < b);
        end
        diff_ab = a - b;
        diff_ba = b - a;
    end

    // Result selection by opcode; undefined opcodes give zero.
    always_comb begin
        unique case (op)
            OP_AVG:  res = avg_res;
            OP_ABSD: res = a_gt_b_u ? diff_ab : diff_ba;
            OP_MIN:  res = a_lt_b ? a : b;
            OP_MAX:  res = a_gt_b ? a : b;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/media_lane_bank.sv
// Module: media_lane_bank
// Splits two data words into lanes of one fixed width and runs a lane unit on
// each. Assumes DATA_W is a whole multiple of LANE_W.
module media_lane_bank
    import media_simd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [OP_W-1:0]   op,
    input  logic              sgn,
    output logic [DATA_W-1:0] res
);

    localparam int NUM_LANES = DATA_W / LANE_W;

    // One lane unit per slice of the word; slices never share logic.
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        media_lane #(
            .LANE_W(LANE_W)
        ) u_lane (
            .a  (a[i*LANE_W +: LANE_W]),
            .b  (b[i*LANE_W +: LANE_W]),
            .op (op),
            .sgn(sgn),
            .res(res[i*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/media_simd_alu.sv
// Module: media_simd_alu (top)
// Two-stage packed integer unit: stage one registers the request, stage two
// registers the lane results selected by the width code. Latency is two cycles,
// one request per cycle, no backpressure. Synchronous active-low reset.
// Assumes DATA_W is a multiple of the widest lane (MIN_LANE_W << (NUM_WIDTHS-1)).
module media_simd_alu
    import media_simd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [OP_W-1:0]   in_op,
    input  logic [WSEL_W-1:0] in_width,
    input  logic              in_signed,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic              s1_valid;
    logic [DATA_W-1:0] s1_a;
    logic [DATA_W-1:0] s1_b;
    logic [OP_W-1:0]   s1_op;
    logic [WSEL_W-1:0] s1_width;
    logic              s1_signed;

    logic [DATA_W-1:0] bank_res [NUM_WIDTHS];
    logic [DATA_W-1:0] sel_res;

    // Stage one: capture the request; payload loads only for valid requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_a      <= '0;
            s1_b      <= '0;
            s1_op     <= '0;
            s1_width  <= '0;
            s1_signed <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_a      <= in_a;
                s1_b      <= in_b;
                s1_op     <= in_op;
                s1_width  <= in_width;
                s1_signed <= in_signed;
            end
        end
    end

    // One lane bank per supported width, all evaluated in parallel.
    for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_bank
        media_lane_bank #(
            .DATA_W(DATA_W),
            .LANE_W(MIN_LANE_W << g)
        ) u_bank (
            .a  (s1_a),
            .b  (s1_b),
            .op (s1_op),
            .sgn(s1_signed),
            .res(bank_res[g])
        );
    end

    // Pick the bank matching the width code; the reserved code gives zero.
    always_comb begin
        sel_res = '0;
        for (int g = 0; g < NUM_WIDTHS; g++) begin
            if (s1_width == WSEL_W'(g)) begin
                sel_res = bank_res[g];
            end
        end
    end

    // Stage two: register the result; hold it while no valid word arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_data <= sel_res;
            end
        end
    end

endmodule

// File: rtl/media_simd_alu_chk.sv
// Module: media_simd_alu_chk
// Property checker bound to media_simd_alu. Watches timing of the valid
// pipeline, zero results for unused codes, result holding and reset.
module media_simd_alu_chk
    import media_simd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic [OP_W-1:0]   in_op,
    input logic [WSEL_W-1:0] in_width,
    input logic              in_signed,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    logic [1:0] since_rst;

    // Count edges since reset release, saturating, to guard two-deep lookbacks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R9: output valid follows input valid exactly two cycles later.
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R8: unused opcodes give an all-zero word.
    p_unused_op_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 2'd2) && $past(in_valid, 2) && ($past(in_op, 2) >= 3'd4))
        |-> (out_data == '0));

    // R6: the reserved width code gives an all-zero word.
    p_reserved_width_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 2'd2) && $past(in_valid, 2) && ($past(in_width, 2) == WSEL_RSV))
        |-> (out_data == '0));

    // R11: no valid output means the data word is unchanged.
    p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid) |-> $stable(out_data));

    // R10: a reset edge clears both outputs.
    p_reset_clears_r10: assert property (@(posedge clk)
        (!rst_n) |=> ((out_valid == 1'b0) && (out_data == '0)));

endmodule

bind media_simd_alu media_simd_alu_chk #(
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_a     (in_a),
    .in_b     (in_b),
    .in_op    (in_op),
    .in_width (in_width),
    .in_signed(in_signed),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/media_simd_alu_test.sv
`timescale 1ns/1ps
// Bench for media_simd_alu: full sweep of 8-bit lane pairs for every operation
// and signedness, boundary and pseudo-random words at 16 and 32 bits, unused
// codes, idle gaps and reset. Expected words computed arithmetically here.
module media_simd_alu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic [2:0]  in_op = '0;
    logic [1:0]  in_width = '0;
    logic        in_signed = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Expected-value pipeline mirroring the two-cycle latency.
    logic        v_d1 = 1'b0, v_d2 = 1'b0;
    logic [63:0] e_d1 = '0, e_d2 = '0;
    string       t_d1 = "", t_d2 = "";
    logic [63:0] last_exp = '0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #2 clk = ~clk;

    media_simd_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .in_op(in_op),
        .in_width(in_width), .in_signed(in_signed),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [63:0] next_rng(input logic [63:0] s);
        logic [63:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    // Reference word computed lane by lane from the requirements.
    function automatic logic [63:0] ref_word(input logic [63:0] a, input logic [63:0] b,
                                             input logic [2:0] op, input logic [1:0] ws,
                                             input logic sg);
        logic [63:0] out = '0;
        int w, n;
        longint mask, ua, ub, sa, sb, r;
        if (ws == 2'd3 || op > 3'd3) return '0;
        w = 8 << ws;
        n = 64 / w;
        mask = (longint'(1) << w) - 1;
        for (int i = 0; i < n; i++) begin
            ua = longint'((a >> (i * w))) & mask;
            ub = longint'((b >> (i * w))) & mask;
            sa = (sg && ((ua >> (w - 1)) & 1) == 1) ? ua - (longint'(1) << w) : ua;
            sb = (sg && ((ub >> (w - 1)) & 1) == 1) ? ub - (longint'(1) << w) : ub;
            case (op)
                3'd0: r = (sa + sb + 1) >>> 1;
                3'd1: r = (ua > ub) ? ua - ub : ub - ua;
                3'd2: r = (sa < sb) ? ua : ub;
                default: r = (sa > sb) ? ua : ub;
            endcase
            out = out | (64'(r & mask) << (i * w));
        end
        return out;
    endfunction

    function automatic string op_tag(input logic [2:0] op, input logic sg);
        case (op)
            3'd0: return sg ? "R2" : "R1";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            default: return "R8";
        endcase
    endfunction

    // One cycle: check the output due now, then present the next request.
    task automatic step(input logic v, input logic [63:0] a, input logic [63:0] b,
                        input logic [2:0] op, input logic [1:0] ws, input logic sg,
                        input string tag);
        @(negedge clk);
        checks++;
        if (out_valid !== v_d2) begin
            fails++;
            $display("FAIL R9 out_valid actual=%0b expected=%0b", out_valid, v_d2);
        end
        checks++;
        if (v_d2) begin
            if (out_data !== e_d2) begin
                fails++;
                $display("FAIL %s data actual=%h expected=%h", t_d2, out_data, e_d2);
            end
            last_exp = e_d2;
        end else if (out_data !== last_exp) begin
            fails++;
            $display("FAIL R11 idle data actual=%h expected=%h", out_data, last_exp);
        end
        v_d2 = v_d1; e_d2 = e_d1; t_d2 = t_d1;
        in_valid = v; in_a = a; in_b = b; in_op = op; in_width = ws; in_signed = sg;
        v_d1 = v;
        if (v) begin
            e_d1 = ref_word(a, b, op, ws, sg);
            t_d1 = tag;
        end
    endtask

    task automatic idle();
        step(1'b0, 64'hDEAD_BEEF_0BAD_F00D, 64'h1234_5678_9ABC_DEF0, 3'd0, 2'd0, 1'b0, "R9");
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] bnd [8];
        // R10: outputs zero under reset even with requests present.
        in_valid = 1'b1; in_a = '1; in_b = '1; in_op = 3'd3;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0 || out_data !== 64'd0) begin
                fails++;
                $display("FAIL R10 reset outputs actual=%0b/%h expected=0/0", out_valid, out_data);
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6: every 8-bit pair, eight pairs per word.
        for (int op = 0; op < 4; op++) begin
            for (int sg = 0; sg < 2; sg++) begin
                for (int x = 0; x < 256; x++) begin
                    for (int yb = 0; yb < 32; yb++) begin
                        logic [63:0] wa, wb;
                        for (int l = 0; l < 8; l++) begin
                            wa[l*8 +: 8] = 8'(x + l * 29);
                            wb[l*8 +: 8] = 8'(yb * 8 + l);
                        end
                        step(1'b1, wa, wb, 3'(op), 2'd0, sg[0], op_tag(3'(op), sg[0]));
                    end
                end
            end
        end

        // R7: all-ones and sign-boundary words at every width and operation.
        bnd[0] = 64'hFFFF_FFFF_FFFF_FFFF; bnd[1] = 64'h0000_0000_0000_0000;
        bnd[2] = 64'h7F7F_7F7F_7F7F_7F7F; bnd[3] = 64'h8080_8080_8080_8080;
        bnd[4] = 64'h7FFF_7FFF_7FFF_7FFF; bnd[5] = 64'h8000_8000_8000_8000;
        bnd[6] = 64'h7FFF_FFFF_8000_0000; bnd[7] = 64'h0000_0001_FFFF_FFFF;
        for (int ws = 0; ws < 3; ws++)
            for (int op = 0; op < 4; op++)
                for (int sg = 0; sg < 2; sg++)
                    for (int i = 0; i < 8; i++)
                        for (int j = 0; j < 8; j++)
                            step(1'b1, bnd[i], bnd[j], 3'(op), 2'(ws), sg[0], "R7");

        // R6: pseudo-random words at 16 and 32 bits, idle gaps for R9 and R11.
        for (int k = 0; k < 6000; k++) begin
            logic [63:0] ra, rb;
            logic [2:0] op;
            rng = next_rng(rng); ra = rng;
            rng = next_rng(rng); rb = rng;
            op = 3'(k % 4);
            if (k % 7 == 3) rb = ra;
            step(1'b1, ra, rb, op, 2'(1 + (k % 2)), rng[5], "R6");
            if (k % 5 == 0) idle();
            if (k % 11 == 0) begin idle(); idle(); end
        end

        // R8 and R6 reserved codes: unused opcodes and width 3 give zero.
        for (int k = 0; k < 64; k++) begin
            rng = next_rng(rng);
            step(1'b1, rng, ~rng, 3'(4 + (k % 4)), 2'(k % 3), k[0], "R8");
            step(1'b1, rng, rng ^ 64'h5555, 3'(k % 4), 2'd3, k[1], "R6");
        end

        // Drain the pipeline, then one more reset check.
        idle(); idle(); idle();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_data !== 64'd0) begin
            fails++;
            $display("FAIL R10 reset outputs actual=%0b/%h expected=0/0", out_valid, out_data);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule